// File: doc/BRIEF.md
# Fixed-Angle Cascaded Rotation Pipeline

This block rotates a stream of two-dimensional fixed-point vectors through one angle that is fixed when the block is elaborated. The angle is built from a short list of micro-rotations. Each micro-rotation has a right-shift amount and a turning sense, and both are elaboration-time parameters. Every micro-rotation gets its own stage, and each stage has one adder or subtractor per coordinate. The shifted copy of the opposite coordinate is formed purely by wiring: the operand is moved down by the shift amount and the vacated upper bits repeat the sign. No stage contains a barrel shifter, a direction register or an angle accumulator. Scale correction is left to the consumer.

Stages are registered and chained: stage 0 takes the input vector and the last stage drives the result. A new vector can enter on every clock. Inputs arrive on a valid/ready stream and results leave on another. When the consumer withholds ready while a result is waiting, the whole chain freezes, the input side drops ready, and the waiting result stays on the output pins. Input samples are signed with `DATA_W` bits. Outputs carry `GROW_W` extra bits so that the rotation gain cannot wrap.

Top module: `cfr_rotator`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and directly after it is released, `out_valid` is 0. `in_ready` is 1 while `out_ready` is 0.
- R2: Stage i applies its shift s(i) as an arithmetic right shift that rounds toward minus infinity. Its direction bit is `DIR_LIST[i]`. With the bit at 0 (counter-clockwise) the stage computes x' = x − (y>>>s), y' = y + (x>>>s). With the bit at 1 (clockwise) it computes x' = x + (y>>>s), y' = y − (x>>>s).
- R3: Each result equals its accepted input after stage 0, then stage 1, and so on through stage `N_STAGES`−1, in that order. Stage i's shift is `SHIFT_LIST[i*5 +: 5]`.
- R4: With `out_ready` held high, a vector accepted at one rising edge shows `out_valid` after exactly `N_STAGES` rising edges, counting the accepting edge. One vector per cycle is sustained. No more than `N_STAGES` vectors are in flight at once.
- R5: If `out_valid` is 1 and `out_ready` is 0, then `in_ready` is 0, no input is taken, and `out_valid`, `out_x` and `out_y` hold their values at the next edge. Otherwise `in_ready` is 1.
- R6: `out_valid` is raised only for accepted inputs. Results leave in acceptance order, one per accepted input, with nothing lost or repeated.
- R7: Inputs are sign-extended to `DATA_W+GROW_W` bits before stage 0. Full-scale negative and positive inputs produce correct signed results with no wrap.
- R8: Values on `in_x`/`in_y` while `in_valid` is 0 have no effect and create no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block accepts an input this cycle |
| in_x | input | DATA_W | Input x coordinate, signed |
| in_y | input | DATA_W | Input y coordinate, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_x | output | DATA_W+GROW_W | Rotated x coordinate, signed |
| out_y | output | DATA_W+GROW_W | Rotated y coordinate, signed |

## Verification
Three events can fall in the same cycle: a new vector is accepted, the oldest result is delivered, and a stall starts or ends. The bench provokes these collisions with random `in_valid` and `out_ready` patterns on a pipeline kept near full, including cycles in which the consumer releases back-pressure while the producer is still presenting data. Each cycle is judged against a behavioural queue model of ages and expected values. The model checks `in_ready`, `out_valid`, and the held or advanced result values.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  // Bits per entry in the packed shift list
  localparam int unsigned CFR_SH_W = 5;

  // Turning sense of one micro-rotation
  typedef enum logic {
    ROT_CCW = 1'b0,
    ROT_CW  = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/cfr_preshift.sv
// Hardwired arithmetic right shift: pure wiring, no multiplexers.
module cfr_preshift #(
  parameter int OW    = 18,
  parameter int SHIFT = 1
) (
  input  logic [OW-1:0] din,
  output logic [OW-1:0] dout
);
  generate
    if (SHIFT == 0) begin : g_pass
      assign dout = din;
    end else begin : g_shift
      // top SHIFT positions repeat the sign, the rest take the upper bits
      assign dout = {{SHIFT{din[OW-1]}}, din[OW-1:SHIFT]};
    end
  endgenerate
endmodule

// File: rtl/cfr_stage.sv
// One dedicated micro-rotation with fixed shift and fixed add/sub sense.
module cfr_stage
  import cfr_pkg::*;
#(
  parameter int       OW    = 18,
  parameter int       SHIFT = 1,
  parameter rot_dir_e DIR   = ROT_CCW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 vin,
  input  logic signed [OW-1:0] xin,
  input  logic signed [OW-1:0] yin,
  output logic                 vout,
  output logic signed [OW-1:0] xo,
  output logic signed [OW-1:0] yo
);
  logic signed [OW-1:0] xsh, ysh, xnx, ynx;

  cfr_preshift #(.OW(OW), .SHIFT(SHIFT)) u_shx (.din(xin), .dout(xsh));
  cfr_preshift #(.OW(OW), .SHIFT(SHIFT)) u_shy (.din(yin), .dout(ysh));

  generate
    if (DIR == ROT_CW) begin : g_cw
      assign xnx = xin + ysh;
      assign ynx = yin - xsh;
    end else begin : g_ccw
      assign xnx = xin - ysh;
      assign ynx = yin + xsh;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      xo   <= '0;
      yo   <= '0;
    end else if (en) begin
      vout <= vin;
      if (vin) begin
        xo <= xnx;
        yo <= ynx;
      end
    end
  end

  AST_VALID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (vout == $past(vin))); // R4

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(vout) && $stable(xo) && $stable(yo))); // R5
endmodule

// File: rtl/cfr_rotator.sv
module cfr_rotator
  import cfr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int GROW_W   = 2,
  parameter int N_STAGES = 7,
  parameter logic [N_STAGES*CFR_SH_W-1:0] SHIFT_LIST =
    {5'd13, 5'd12, 5'd11, 5'd9, 5'd7, 5'd3, 5'd1},
  parameter logic [N_STAGES-1:0] DIR_LIST = 7'b1100010
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [DATA_W-1:0]          in_x,
  input  logic [DATA_W-1:0]          in_y,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DATA_W+GROW_W-1:0]   out_x,
  output logic [DATA_W+GROW_W-1:0]   out_y
);
  localparam int OW    = DATA_W + GROW_W;
  localparam int CNT_W = $clog2(N_STAGES + 2);

  logic signed [OW-1:0] xs [0:N_STAGES];
  logic signed [OW-1:0] ys [0:N_STAGES];
  logic                 vs [0:N_STAGES];
  logic                 adv;

  // whole chain moves unless a finished result is blocked
  assign adv      = !vs[N_STAGES] || out_ready;
  assign in_ready = adv;

  assign vs[0] = in_valid;
  assign xs[0] = {{GROW_W{in_x[DATA_W-1]}}, in_x};
  assign ys[0] = {{GROW_W{in_y[DATA_W-1]}}, in_y};

  generate
    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      localparam int       S = int'(SHIFT_LIST[i*CFR_SH_W +: CFR_SH_W]);
      localparam rot_dir_e D = rot_dir_e'(DIR_LIST[i]);
      cfr_stage #(.OW(OW), .SHIFT(S), .DIR(D)) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (adv),
        .vin  (vs[i]),
        .xin  (xs[i]),
        .yin  (ys[i]),
        .vout (vs[i+1]),
        .xo   (xs[i+1]),
        .yo   (ys[i+1])
      );
    end
  endgenerate

  assign out_valid = vs[N_STAGES];
  assign out_x     = xs[N_STAGES];
  assign out_y     = ys[N_STAGES];

  // In-flight tally kept only for the properties below
  logic [CNT_W-1:0] chk_cnt;
  logic             chk_in, chk_out;
  assign chk_in  = in_valid && in_ready;
  assign chk_out = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_cnt <= '0;
    else if (chk_in && !chk_out) chk_cnt <= chk_cnt + 1'b1;
    else if (!chk_in && chk_out) chk_cnt <= chk_cnt - 1'b1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y))); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (chk_cnt != '0)); // R6

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chk_cnt <= CNT_W'(N_STAGES)); // R4
endmodule

// File: tb/test_cfr_rotator.sv
module test_cfr_rotator;
  localparam int N  = 7;
  localparam int DW = 16;
  localparam int OW = 18;
  localparam logic [N*5-1:0] P_SH = {5'd13, 5'd12, 5'd11, 5'd9, 5'd7, 5'd3, 5'd1};
  localparam logic [N-1:0]   P_DR = 7'b1100010;
  int sh_tab [N] = '{1, 3, 7, 9, 11, 12, 13};
  bit dr_tab [N] = '{0, 1, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_x = '0, in_y = '0;
  logic signed [OW-1:0] out_x, out_y;

  always #4 clk = ~clk; // 125 MHz

  cfr_rotator #(.DATA_W(DW), .GROW_W(OW-DW), .N_STAGES(N),
                .SHIFT_LIST(P_SH), .DIR_LIST(P_DR)) i_cfr_rotator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y));

  typedef struct { longint ex; longint ey; int age; } ent_t;
  ent_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0, last_ov = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R2/R3 reference: stages applied in list order with floor shifts
  task automatic rot(input longint x0, input longint y0, output longint xr, output longint yr);
    longint x = x0, y = y0, tx, ty;
    for (int i = 0; i < N; i++) begin
      tx = x >>> sh_tab[i];
      ty = y >>> sh_tab[i];
      if (dr_tab[i]) begin x = x + ty; y = y - tx; end
      else           begin x = x - ty; y = y + tx; end
    end
    xr = x; yr = y;
  endtask

  task automatic step(input bit iv, input logic signed [DW-1:0] ix,
                      input logic signed [DW-1:0] iy, input bit ordy);
    bit mv, adv;
    longint ex, ey;
    @(negedge clk);
    mv = (q.size() > 0) && (q[0].age == N);
    chk(out_valid == mv, "R6 out_valid", longint'(out_valid), longint'(mv));
    if (mv && out_valid) begin
      chk(longint'(out_x) == q[0].ex, "R3 out_x", longint'(out_x), q[0].ex);
      chk(longint'(out_y) == q[0].ey, "R3 out_y", longint'(out_y), q[0].ey);
    end
    chk(in_ready == (!mv || out_ready), "R5 in_ready", longint'(in_ready),
        longint'(!mv || out_ready));
    last_ov = out_valid;
    in_valid  = iv;
    in_x      = ix;
    in_y      = iy;
    out_ready = ordy;
    adv = !mv || ordy;
    if (adv) begin
      if (mv) void'(q.pop_front());
      foreach (q[k]) q[k].age++;
      if (iv) begin
        rot(longint'(ix), longint'(iy), ex, ey);
        q.push_back('{ex: ex, ey: ey, age: 1});
      end
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // R4 latency of one vector
    step(1, 16'sd20000, 16'sd0, 1);
    lat = 0;
    for (int k = 1; k <= N + 3; k++) begin
      step(0, 16'sd0, 16'sd0, 1);
      if (last_ov && lat == 0) lat = k;
    end
    chk(lat == N, "R4 latency", lat, N);

    // R8 garbage with in_valid low
    for (int k = 0; k < N + 4; k++) step(0, 16'sh3039, -16'sd777, 1);
    chk(last_ov == 1'b0, "R8 no result from idle data", longint'(last_ov), 0);

    // R7 extremes and R4 full-rate burst
    step(1, -16'sd32768, -16'sd32768, 1);
    step(1, 16'sd32767, 16'sd32767, 1);
    step(1, -16'sd32768, 16'sd32767, 1);
    step(1, 16'sd1, -16'sd1, 1);
    for (int k = 0; k < 40; k++) step(1, DW'($urandom), DW'($urandom), 1);

    // R5 long stall on a full pipe, then drain
    for (int k = 0; k < 12; k++) step(1, DW'($urandom), DW'($urandom), 0);
    for (int k = 0; k < N + 4; k++) step(0, 16'sd0, 16'sd0, 1);

    // R6/R5 random valid/ready collisions
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, DW'($urandom), DW'($urandom), ($urandom % 3) != 0);
    for (int k = 0; k < N + 4; k++) step(0, 16'sd0, 16'sd0, 1);
    chk(q.size() == 0, "R6 all results delivered", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule